// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a register-mapped timer that produces a steady stream of periodic events from the system clock. A fixed prescaler divides the clock into slow ticks. A period counter counts those ticks from zero up to a programmed limit and then returns to zero. Each return to zero is one completed period. A wrap counter records how many periods have completed, and a pending flag records that at least one has completed. The pending flag, gated by an interrupt enable, drives a level interrupt line.

Software sees four 32-bit word registers on a simple synchronous bus. There is a mode register, a pending-flag register and two views of the live count. Both views show the wrap counter and the period counter. Reading the first view acknowledges the timer, which clears the pending flag and the wrap counter. Reading the second view leaves both untouched, so a free-running time base can be sampled without disturbing interrupt handling. When software turns the timer off, the current period still runs to its end, and the counter then rests at zero.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads zero, the interrupt line is low and nothing counts.
- R2: While running, the period counter advances by one once every PRESCALE clocks.
- R3: Word 0 (byte offset 0x0) is the mode register. It holds the period limit in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25, and it reads back as written with all other bits zero.
- R4: A completed period means the counter returns to zero after limit+1 ticks. Each completed period sets the pending flag, which reads in bit 0 of word 1 (offset 0x4) and stays set until an acknowledge.
- R5: Word 2 (offset 0x8) returns the wrap count in bits 31:20 and the period counter in bits 19:0. Reading it clears the pending flag and the wrap count.
- R6: Word 3 (offset 0xC) returns the same fields as word 2, and reading it changes neither the pending flag nor the wrap count.
- R7: The wrap count rolls over modulo 4096, and the pending flag stays set across the rollover.
- R8: If a period completes in the same cycle as a word 2 read, the read returns the old values. Afterwards the pending flag is set and the wrap count is 1.
- R9: Clearing the run enable lets the counter continue to the end of the current period. It then holds at zero. With the run enable clear and the counter at zero, nothing counts.
- R10: The interrupt line is high exactly while the pending flag and the interrupt enable are both set. Clearing the interrupt enable does not stop counting.
- R11: Each time counting starts from rest, the prescaler starts from zero. The first increment therefore comes PRESCALE clocks after the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with PRESCALE set to 4 and the default field widths of 20 and 12 bits. The short tick keeps each period short, so a full rollover of the 12-bit wrap counter happens within about sixteen thousand clocks when the period limit is 0. At that limit every tick completes a period, and the bench reads the wrap count on both sides of the rollover from 4095 to 0. A period limit of 9 gives ten-tick periods. With that limit the bench lines up a word 2 read with an exact period boundary, and it stops the timer in the middle of a period.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_FLAG  = 2'd1,
    SEL_VALUE = 2'd2,
    SEL_IMAGE = 2'd3
  } itmr_sel_e;

  localparam int unsigned RUN_BIT    = 24;
  localparam int unsigned IRQ_EN_BIT = 25;

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  generate
    if (DIV < 2) begin : g_bypass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] phase_q;

      // phase returns to zero whenever counting pauses
      always_ff @(posedge clk) begin
        if (rst || !run)          phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
      end

      assign tick = run && (phase_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/itmr_period_cnt.sv
module itmr_period_cnt #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value,
  output logic         wrap
);

  logic [W-1:0] value_q;

  // >= keeps the counter bounded if the limit is lowered mid-period
  assign wrap = tick && (value_q >= limit);

  always_ff @(posedge clk) begin
    if (rst)       value_q <= '0;
    else if (tick) value_q <= wrap ? '0 : value_q + 1'b1;
  end

  assign value = value_q;

endmodule

// File: rtl/itmr_wrap_track.sv
module itmr_wrap_track #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrap,
  input  logic         ack,
  output logic [W-1:0] count,
  output logic         flag,
  output logic         flag_next
);

  logic [W-1:0] count_q, count_d;
  logic         flag_q, flag_d;

  always_comb begin
    count_d = count_q;
    flag_d  = flag_q;
    if (ack) begin
      // a wrap landing on the acknowledge survives it
      count_d = wrap ? W'(1) : '0;
      flag_d  = wrap;
    end else if (wrap) begin
      count_d = count_q + 1'b1;
      flag_d  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      flag_q  <= flag_d;
    end
  end

  assign count     = count_q;
  assign flag      = flag_q;
  assign flag_next = flag_d;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned PERIOD_W = 20,
  parameter int unsigned WRAP_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam logic [DATA_W-1:0] MODE_MASK =
      (DATA_W'(1) << IRQ_EN_BIT) | (DATA_W'(1) << RUN_BIT) |
      ((DATA_W'(1) << PERIOD_W) - DATA_W'(1));

  itmr_sel_e sel;
  assign sel = itmr_sel_e'(bus_addr);

  logic mode_wr, ack;
  assign mode_wr = bus_en &&  bus_we && (sel == SEL_MODE);
  assign ack     = bus_en && !bus_we && (sel == SEL_VALUE);

  logic [DATA_W-1:0] mode_q;
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= bus_wdata & MODE_MASK;
  end

  logic [PERIOD_W-1:0] limit;
  logic                run_en, irq_en, irq_en_next;
  assign limit       = mode_q[PERIOD_W-1:0];
  assign run_en      = mode_q[RUN_BIT];
  assign irq_en      = mode_q[IRQ_EN_BIT];
  assign irq_en_next = mode_wr ? bus_wdata[IRQ_EN_BIT] : irq_en;

  logic [PERIOD_W-1:0] count;
  logic [WRAP_W-1:0]   wrap_cnt;
  logic run, tick, wrap, flag, flag_next;

  // a disabled timer finishes its period before resting
  assign run = run_en || (count != '0);

  itmr_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk (clk), .rst (rst), .run (run), .tick (tick)
  );

  itmr_period_cnt #(.W(PERIOD_W)) u_cnt (
    .clk (clk), .rst (rst), .tick (tick), .limit (limit),
    .value (count), .wrap (wrap)
  );

  itmr_wrap_track #(.W(WRAP_W)) u_trk (
    .clk (clk), .rst (rst), .wrap (wrap), .ack (ack),
    .count (wrap_cnt), .flag (flag), .flag_next (flag_next)
  );

  logic [DATA_W-1:0] snapshot;
  always_comb begin
    snapshot = '0;
    snapshot[PERIOD_W-1:0]       = count;
    snapshot[DATA_W-1 -: WRAP_W] = wrap_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      unique case (sel)
        SEL_MODE:  bus_rdata <= mode_q;
        SEL_FLAG:  bus_rdata <= DATA_W'(flag);
        SEL_VALUE: bus_rdata <= snapshot;
        SEL_IMAGE: bus_rdata <= snapshot;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag_next && irq_en_next;
  end

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int unsigned PERIOD_W = 20,
  parameter int unsigned WRAP_W   = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                irq,
  input logic                irq_en,
  input logic                run_en,
  input logic                flag,
  input logic [WRAP_W-1:0]   wrap_cnt,
  input logic [PERIOD_W-1:0] count,
  input logic                tick,
  input logic                wrap,
  input logic                ack
);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && irq_en));

  a_r10_irq_when_armed: assert property (@(posedge clk) disable iff (rst)
    (flag && irq_en) |-> irq);

  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !wrap) |=> (!flag && wrap_cnt == '0));

  a_r8_ack_collision: assert property (@(posedge clk) disable iff (rst)
    (ack && wrap) |=> (flag && wrap_cnt == WRAP_W'(1)));

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  a_r9_rest_stays: assert property (@(posedge clk) disable iff (rst)
    (!run_en && count == '0) |=> (count == '0));

endmodule

bind interval_timer itmr_checker #(.PERIOD_W(PERIOD_W), .WRAP_W(WRAP_W)) u_itmr_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .irq_en   (irq_en),
  .run_en   (run_en),
  .flag     (flag),
  .wrap_cnt (wrap_cnt),
  .count    (count),
  .tick     (tick),
  .wrap     (wrap),
  .ack      (ack)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2 clk = ~clk;

  interval_timer #(.PRESCALE(P)) dut (
    .clk (clk), .rst (rst), .bus_en (bus_en), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq (irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // reference model state
  int W = 0;
  int per = 0;
  int ack_n = 0;
  int stop_n = 32'h7fffffff;
  bit ien_m = 1'b0;

  function automatic int eff(int n);
    return (n < stop_n) ? n : stop_n;
  endfunction
  function automatic int m_cnt(int n);
    return (eff(n) / P) % (per + 1);
  endfunction
  function automatic int m_wr(int n);
    return eff(n) / (P * (per + 1));
  endfunction
  function automatic int m_pic(int n);
    return (m_wr(n) - m_wr(ack_n)) % 4096;
  endfunction
  function automatic bit m_stat(int n);
    return m_wr(n) > m_wr(ack_n);
  endfunction
  function automatic logic [31:0] m_val(int n);
    return (32'(m_pic(n)) << 20) | 32'(m_cnt(n));
  endfunction
  function automatic logic [31:0] mk(int pv, bit en, bit ie);
    return (32'(ie) << 25) | (32'(en) << 24) | 32'(pv);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d, output int n);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; n = cyc - 1 - W;
    bus_en = 1'b0;
  endtask

  task automatic wait_strobe_at(int edge_no);
    while (cyc < edge_no - 1) @(negedge clk);
  endtask

  task automatic chk_image(string tag);
    logic [31:0] d; int n;
    rd(2'd3, d, n);
    check(d == m_val(n), tag, d, m_val(n));
  endtask

  task automatic chk_ack(string tag);
    logic [31:0] d; int n;
    rd(2'd2, d, n);
    check(d == m_val(n), tag, d, m_val(n));
    ack_n = n;
  endtask

  task automatic chk_flag(string tag);
    logic [31:0] d; int n;
    rd(2'd1, d, n);
    check(d == 32'(m_stat(n)), tag, d, 32'(m_stat(n)));
  endtask

  task automatic chk_irq(string tag);
    bit e;
    e = ien_m && m_stat(cyc - W);
    check(irq == e, tag, irq, e);
  endtask

  task automatic start_run(int pv, bit ie);
    wr(2'd0, mk(pv, 1'b1, ie));
    W = cyc; per = pv; ack_n = 0; stop_n = 32'h7fffffff; ien_m = ie;
  endtask

  task automatic halt_run();
    int nd, L;
    wr(2'd0, mk(per, 1'b0, ien_m));
    nd = cyc - W; L = P * (per + 1);
    stop_n = (m_cnt(nd) == 0) ? nd : ((nd / L) + 1) * L;
  endtask

  task automatic t_reset();
    logic [31:0] d; int n;
    check(irq == 1'b0, "R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d, n);
      check(d == 32'h0, "R1 register", d, 0);
    end
  endtask

  task automatic t_idle_mode();
    logic [31:0] d; int n;
    wr(2'd0, mk(5, 1'b0, 1'b1) | 32'hFC00_0000);
    rd(2'd0, d, n);
    check(d == mk(5, 1'b0, 1'b1), "R3 mode readback", d, mk(5, 1'b0, 1'b1));
    repeat (30) @(negedge clk);
    rd(2'd3, d, n);
    check(d == 32'h0, "R9 disabled no count", d, 0);
    check(irq == 1'b0, "R10 no flag no irq", irq, 0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_count();
    start_run(9, 1'b0);
    wait_strobe_at(W + P);
    chk_image("R11 before first tick");
    chk_image("R11 first tick");
    repeat (9) @(negedge clk);
    chk_image("R2 mid period");
    repeat (60) @(negedge clk);
    chk_image("R6 image after wraps");
    chk_image("R6 image repeat");
    chk_flag("R4 flag set");
    chk_ack("R5 value read");
    chk_flag("R5 flag after ack");
    chk_image("R5 count after ack");
  endtask

  task automatic t_collision();
    logic [31:0] d; int n, k;
    k = m_wr(cyc - W) + 2;
    wait_strobe_at(W + k * P * (per + 1));
    chk_ack("R8 value on boundary");
    rd(2'd3, d, n);
    check(d[31:20] == 12'd1, "R8 wrap count one", d[31:20], 1);
    chk_flag("R8 flag kept");
  endtask

  task automatic t_irq();
    int k;
    wr(2'd0, mk(per, 1'b1, 1'b1)); ien_m = 1'b1;
    chk_irq("R10 irq on enable");
    check(irq == 1'b1, "R10 irq pending", irq, 1);
    chk_ack("R10 ack");
    chk_irq("R10 irq after ack");
    k = m_wr(cyc - W) + 1;
    while (cyc < W + k * P * (per + 1) + 2) @(negedge clk);
    chk_irq("R10 irq after wrap");
    wr(2'd0, mk(per, 1'b1, 1'b0)); ien_m = 1'b0;
    chk_irq("R10 irq masked");
    chk_image("R10 counting while masked");
    repeat (17) @(negedge clk);
    chk_image("R10 still counting");
  endtask

  task automatic t_stop();
    chk_ack("R9 ack before stop");
    while (m_cnt(cyc + 1 - W) != 5) @(negedge clk);
    halt_run();
    chk_image("R9 still running after disable");
    repeat (50) @(negedge clk);
    chk_image("R9 rests at zero");
    repeat (100) @(negedge clk);
    chk_image("R9 rest is stable");
    chk_flag("R9 final period flagged");
  endtask

  task automatic t_restart();
    chk_ack("R11 ack at rest");
    start_run(9, 1'b0);
    wait_strobe_at(W + P);
    chk_image("R11 restart before tick");
    chk_image("R11 restart first tick");
    halt_run();
    repeat (60) @(negedge clk);
    chk_ack("R9 clear after second stop");
  endtask

  task automatic t_rollover();
    logic [31:0] d; int n;
    start_run(0, 1'b0);
    wait_strobe_at(W + 16384);
    rd(2'd3, d, n);
    check(d[31:20] == 12'd4095, "R7 count at 4095", d[31:20], 4095);
    rd(2'd3, d, n);
    check(d == 32'h0, "R7 rolled to zero", d, 0);
    chk_flag("R7 flag survives rollover");
    chk_image("R7 model after rollover");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_mode();
    t_count();
    t_collision();
    t_irq();
    t_stop();
    t_restart();
    t_rollover();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule